// File: doc/BRIEF.md
# Multiplexed-Address DRAM Model with Row Buffer

This block is a synthesizable behavioural model of a conventional DRAM chip. Storage is a grid of `ROWS` by `COLS` supercells, each `WORD` bits wide, so the default holds 16 supercells of 8 bits in a 4 by 4 grid. The address pins are shared: the row index and the column index travel over them one after the other. A row strobe copies a whole row into an internal row buffer. Each later column strobe picks one supercell out of that buffer and shows it on the read data port. Several column strobes may follow one row strobe, which gives page-mode access.

A write follows the same path. Once a column has been selected, a write-enable pulse with data replaces that supercell in the row buffer. Closing the row (precharge) copies the buffer back into the array.

A cycle counter raises a refresh request once a set number of cycles has passed. A refresh command issued while no row is open reads the next row in round-robin order and writes it back unchanged. A command given in a state where it has no meaning is ignored and flagged with a one-cycle protocol-error pulse.

Top module: `mux_dram`

## Requirements
- R1: When no row is open, `row_stb` with `refresh_go` low opens the row given on `addr`. `row_open` reads 1 from the next cycle on.
- R2: While a row is open, `col_stb` selects column `addr`. One clock later `rd_valid` is 1 and `rd_data` shows that supercell of the open row. Both hold until the next column strobe or the close of the row.
- R3: Further `col_stb` pulses in the same open row select other supercells without a new row strobe (page mode).
- R4: While a column is selected (`rd_valid` = 1), `wr_en` with `col_stb` and `close_row` low replaces the selected supercell in the row buffer with `wr_data`. `rd_data` shows the new value one clock later.
- R5: While a row is open, `close_row` writes the row buffer back into the array. From the next cycle, `row_open` and `rd_valid` are 0 and `rd_data` is 0. A later opening of that row returns the written values.
- R6: `col_stb` with no row open is ignored, and so is `row_stb` while a row is open (the open row and its selection are kept). Either one sets `proto_err` to 1 for exactly the next cycle.
- R7: `refresh_req` rises `REFRESH_CYCLES` cycles after reset or after the last accepted refresh, and stays high until a refresh is accepted.
- R8: `refresh_go` is accepted only when no row is open, and it takes priority over `row_stb` in the same cycle. It clears the counter, so `refresh_req` is 0 the next cycle, and it leaves every stored value unchanged. Rows are refreshed in round-robin order. While a row is open it is ignored.
- R9: Reset (active low, asynchronous) forces `row_open`, `rd_valid`, `proto_err` and `refresh_req` to 0. Array contents are undefined afterwards.
- R10: `wr_en` while no row is open has no effect on outputs or stored data.
- R11: While a row is open, `close_row` has priority over `col_stb` and `wr_en` in the same cycle. The write is dropped and the row closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| addr | input | AW (2) | Shared row/column index |
| row_stb | input | 1 | Row strobe: open the row on `addr` |
| col_stb | input | 1 | Column strobe: select the supercell on `addr` |
| wr_en | input | 1 | Write `wr_data` into the selected supercell of the row buffer |
| wr_data | input | WORD (8) | Write data |
| close_row | input | 1 | Precharge: write back the row buffer and close the row |
| refresh_go | input | 1 | Refresh command |
| rd_data | output | WORD (8) | Selected supercell; 0 when none is selected |
| rd_valid | output | 1 | A supercell is selected and shown on `rd_data` |
| row_open | output | 1 | A row is open |
| proto_err | output | 1 | One-cycle pulse for an ignored strobe |
| refresh_req | output | 1 | Refresh is due |

## Verification
Every command changes the registered state at the clock edge that samples it, so `rd_valid`, `rd_data`, `row_open` and `proto_err` all reflect a command exactly one edge later. The bench drives each command on a falling edge and compares all four outputs on the next falling edge, one edge later. The refresh request is measured from the edge that accepts a refresh: it must still be low after `REFRESH_CYCLES`-1 further edges and high after `REFRESH_CYCLES`. The bench samples both of those edges. Reset is checked while `rst_n` is low, because it clears the outputs at once, and again after the synchronizer has released it.

// File: rtl/mdram_pkg.sv
package mdram_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_OPEN,
    OP_SELECT,
    OP_WRITE,
    OP_CLOSE,
    OP_REFRESH,
    OP_FAULT
  } op_e;
endpackage

// File: rtl/mdram_seq.sv
module mdram_seq
  import mdram_pkg::*;
#(
  parameter int RW = 2,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_stb,
  input  logic          col_stb,
  input  logic          wr_en,
  input  logic          close_row,
  input  logic          refresh_go,
  input  logic [RW-1:0] row_addr,
  input  logic [CW-1:0] col_addr,
  output op_e           op,
  output logic          open_q,
  output logic [RW-1:0] open_row_q,
  output logic          sel_valid_q,
  output logic [CW-1:0] sel_col_q,
  output logic          fault_q
);

  logic open_d, sel_valid_d, fault_d;
  logic row_en, col_en;

  // command decode: priority depends on whether a row is open
  always_comb begin
    op = OP_IDLE;
    if (open_q) begin
      if (close_row)                op = OP_CLOSE;
      else if (col_stb)             op = OP_SELECT;
      else if (wr_en && sel_valid_q) op = OP_WRITE;
      else if (row_stb)             op = OP_FAULT;
    end else begin
      if (refresh_go)               op = OP_REFRESH;
      else if (row_stb)             op = OP_OPEN;
      else if (col_stb)             op = OP_FAULT;
    end
  end

  always_comb begin
    open_d      = open_q;
    sel_valid_d = sel_valid_q;
    fault_d     = 1'b0;
    row_en      = 1'b0;
    col_en      = 1'b0;
    unique case (op)
      OP_OPEN: begin
        open_d      = 1'b1;
        sel_valid_d = 1'b0;
        row_en      = 1'b1;
      end
      OP_SELECT: begin
        sel_valid_d = 1'b1;
        col_en      = 1'b1;
      end
      OP_CLOSE: begin
        open_d      = 1'b0;
        sel_valid_d = 1'b0;
      end
      OP_FAULT: fault_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      sel_valid_q <= 1'b0;
      fault_q     <= 1'b0;
    end else begin
      open_q      <= open_d;
      sel_valid_q <= sel_valid_d;
      fault_q     <= fault_d;
    end
  end

  always_ff @(posedge clk) begin
    if (row_en) open_row_q <= row_addr;
    if (col_en) sel_col_q  <= col_addr;
  end

  a_r2_valid_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid_q |-> open_q);

  a_r3_col_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid_q && !col_stb && !close_row) |=> $stable(sel_col_q));

  a_r1_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !close_row) |=> (open_q && $stable(open_row_q)));

  a_r6_closed_col_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (col_stb && !open_q) |=> (!sel_valid_q && fault_q));

endmodule

// File: rtl/mdram_array.sv
module mdram_array #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int WORD = 8,
  parameter int RW   = 2
) (
  input  logic                 clk,
  input  logic [RW-1:0]        rd_row,
  output logic [COLS*WORD-1:0] rd_line,
  input  logic                 we,
  input  logic [RW-1:0]        wr_row,
  input  logic [COLS*WORD-1:0] wr_line
);

  logic [ROWS-1:0][COLS*WORD-1:0] cells_q;

  assign rd_line = cells_q[rd_row];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic row_we;
    assign row_we = we && (wr_row == RW'(r));
    always_ff @(posedge clk) begin
      if (row_we) cells_q[r] <= wr_line;
    end
  end

endmodule

// File: rtl/mdram_rowbuf.sv
module mdram_rowbuf #(
  parameter int COLS = 4,
  parameter int WORD = 8,
  parameter int CW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [COLS*WORD-1:0] load_line,
  input  logic                 wr,
  input  logic [CW-1:0]        wr_col,
  input  logic [WORD-1:0]      wr_word,
  input  logic                 rd_en,
  input  logic [CW-1:0]        rd_col,
  output logic [WORD-1:0]      rd_word,
  output logic [COLS*WORD-1:0] line_out
);

  logic [COLS-1:0][WORD-1:0] words_q, words_d;
  logic                      buf_en;

  assign buf_en = load | wr;

  always_comb begin
    words_d = words_q;
    if (load) words_d = load_line;
    else if (wr) words_d[wr_col] = wr_word;
  end

  always_ff @(posedge clk) begin
    if (buf_en) words_q <= words_d;
  end

  assign line_out = words_q;
  assign rd_word  = rd_en ? words_q[rd_col] : '0;

  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !load) |=> (words_q[$past(wr_col)] == $past(wr_word)));

endmodule

// File: rtl/mdram_refresh.sv
module mdram_refresh #(
  parameter int ROWS  = 4,
  parameter int LIMIT = 1000,
  parameter int RW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  output logic          req,
  output logic [RW-1:0] ptr_q
);

  localparam int CNTW = $clog2(LIMIT + 1);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [RW-1:0]   ptr_d;

  assign req = (cnt_q == CNTW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    ptr_d = ptr_q;
    if (accept) begin
      cnt_d = '0;
      ptr_d = (ptr_q == RW'(ROWS - 1)) ? '0 : ptr_q + 1'b1;
    end else if (!req) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ptr_q <= ptr_d;
    end
  end

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !accept) |=> req);

  a_r8_clears: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req);

  a_r8_round_robin: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ptr_q == (($past(ptr_q) == RW'(ROWS - 1)) ? '0 : $past(ptr_q) + 1'b1)));

endmodule

// File: rtl/mux_dram.sv
module mux_dram
  import mdram_pkg::*;
#(
  parameter int ROWS           = 4,
  parameter int COLS           = 4,
  parameter int WORD           = 8,
  parameter int REFRESH_CYCLES = 1000,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int AW = (RW > CW) ? RW : CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            row_stb,
  input  logic            col_stb,
  input  logic            wr_en,
  input  logic [WORD-1:0] wr_data,
  input  logic            close_row,
  input  logic            refresh_go,
  output logic [WORD-1:0] rd_data,
  output logic            rd_valid,
  output logic            row_open,
  output logic            proto_err,
  output logic            refresh_req
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  op_e                 op;
  logic                open_q, sel_valid_q, fault_q;
  logic [RW-1:0]       open_row_q, ref_ptr;
  logic [CW-1:0]       sel_col_q;
  logic [COLS*WORD-1:0] arr_line, buf_line, arr_wr_line;
  logic [RW-1:0]       arr_rd_row, arr_wr_row;
  logic                arr_we, buf_load, buf_wr, ref_accept;

  mdram_seq #(.RW(RW), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .row_stb    (row_stb),
    .col_stb    (col_stb),
    .wr_en      (wr_en),
    .close_row  (close_row),
    .refresh_go (refresh_go),
    .row_addr   (addr[RW-1:0]),
    .col_addr   (addr[CW-1:0]),
    .op         (op),
    .open_q     (open_q),
    .open_row_q (open_row_q),
    .sel_valid_q(sel_valid_q),
    .sel_col_q  (sel_col_q),
    .fault_q    (fault_q)
  );

  assign ref_accept  = (op == OP_REFRESH);
  assign arr_rd_row  = ref_accept ? ref_ptr : addr[RW-1:0];
  assign arr_we      = (op == OP_CLOSE) || ref_accept;
  assign arr_wr_row  = (op == OP_CLOSE) ? open_row_q : ref_ptr;
  assign arr_wr_line = (op == OP_CLOSE) ? buf_line : arr_line;
  assign buf_load    = (op == OP_OPEN) || ref_accept;
  assign buf_wr      = (op == OP_WRITE);

  mdram_array #(.ROWS(ROWS), .COLS(COLS), .WORD(WORD), .RW(RW)) u_array (
    .clk    (clk),
    .rd_row (arr_rd_row),
    .rd_line(arr_line),
    .we     (arr_we),
    .wr_row (arr_wr_row),
    .wr_line(arr_wr_line)
  );

  mdram_rowbuf #(.COLS(COLS), .WORD(WORD), .CW(CW)) u_rowbuf (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (buf_load),
    .load_line(arr_line),
    .wr       (buf_wr),
    .wr_col   (sel_col_q),
    .wr_word  (wr_data),
    .rd_en    (sel_valid_q),
    .rd_col   (sel_col_q),
    .rd_word  (rd_data),
    .line_out (buf_line)
  );

  mdram_refresh #(.ROWS(ROWS), .LIMIT(REFRESH_CYCLES), .RW(RW)) u_refresh (
    .clk   (clk),
    .rst_n (rst_int_n),
    .accept(ref_accept),
    .req   (refresh_req),
    .ptr_q (ref_ptr)
  );

  assign rd_valid  = sel_valid_q;
  assign row_open  = open_q;
  assign proto_err = fault_q;

  a_r5_closed_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !row_open |-> (!rd_valid && rd_data == '0));

  a_r10_closed_write_ignored: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!row_open && wr_en && !row_stb && !refresh_go) |=> !row_open);

endmodule

// File: tb/mux_dram_test.sv
`timescale 1ns/1ps
module mux_dram_test;

  localparam int LIM = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addr;
  logic       row_stb, col_stb, wr_en, close_row, refresh_go;
  logic [7:0] wr_data, rd_data;
  logic       rd_valid, row_open, proto_err, refresh_req;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mux_dram #(.REFRESH_CYCLES(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .row_stb(row_stb), .col_stb(col_stb),
    .wr_en(wr_en), .wr_data(wr_data), .close_row(close_row), .refresh_go(refresh_go),
    .rd_data(rd_data), .rd_valid(rd_valid), .row_open(row_open),
    .proto_err(proto_err), .refresh_req(refresh_req)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       rs, cs, we, cl, rf;
    logic [1:0] a;
    logic [7:0] wd;
    logic       dc, ev;
    logic [7:0] ed;
    logic       ee, eo;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{4'd9,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h00, 1'b0,1'b0,8'h00,1'b0,1'b0}, // R9 idle
    '{4'd1,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2, 8'h00, 1'b0,1'b0,8'h00,1'b0,1'b1}, // R1 open row 2
    '{4'd2,  1'b0,1'b1,1'b0,1'b0,1'b0, 2'd1, 8'h00, 1'b1,1'b1,8'h00,1'b0,1'b1}, // R2 select col 1
    '{4'd4,  1'b0,1'b0,1'b1,1'b0,1'b0, 2'd0, 8'hA5, 1'b0,1'b1,8'hA5,1'b0,1'b1}, // R4 write A5
    '{4'd3,  1'b0,1'b1,1'b0,1'b0,1'b0, 2'd3, 8'h00, 1'b1,1'b1,8'h00,1'b0,1'b1}, // R3 col 3
    '{4'd4,  1'b0,1'b0,1'b1,1'b0,1'b0, 2'd0, 8'h3C, 1'b0,1'b1,8'h3C,1'b0,1'b1}, // R4 write 3C
    '{4'd2,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h00, 1'b0,1'b1,8'h3C,1'b0,1'b1}, // R2 hold
    '{4'd5,  1'b0,1'b0,1'b0,1'b1,1'b0, 2'd0, 8'h00, 1'b0,1'b0,8'h00,1'b0,1'b0}, // R5 close
    '{4'd6,  1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0, 8'h00, 1'b0,1'b0,8'h00,1'b1,1'b0}, // R6 col with no row
    '{4'd6,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h00, 1'b0,1'b0,8'h00,1'b0,1'b0}, // R6 pulse ends
    '{4'd10, 1'b0,1'b0,1'b1,1'b0,1'b0, 2'd0, 8'hFF, 1'b0,1'b0,8'h00,1'b0,1'b0}, // R10 write closed
    '{4'd1,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2, 8'h00, 1'b0,1'b0,8'h00,1'b0,1'b1}, // R1 reopen 2
    '{4'd5,  1'b0,1'b1,1'b0,1'b0,1'b0, 2'd1, 8'h00, 1'b0,1'b1,8'hA5,1'b0,1'b1}, // R5 written back
    '{4'd3,  1'b0,1'b1,1'b0,1'b0,1'b0, 2'd3, 8'h00, 1'b0,1'b1,8'h3C,1'b0,1'b1}, // R3 page mode
    '{4'd6,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h00, 1'b0,1'b1,8'h3C,1'b1,1'b1}, // R6 row strobe while open
    '{4'd6,  1'b0,1'b1,1'b0,1'b0,1'b0, 2'd1, 8'h00, 1'b0,1'b1,8'hA5,1'b0,1'b1}, // R6 row 2 kept
    '{4'd8,  1'b0,1'b0,1'b0,1'b0,1'b1, 2'd0, 8'h00, 1'b0,1'b1,8'hA5,1'b0,1'b1}, // R8 refresh ignored
    '{4'd11, 1'b0,1'b1,1'b1,1'b1,1'b0, 2'd3, 8'h00, 1'b0,1'b0,8'h00,1'b0,1'b0}, // R11 close wins
    '{4'd1,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2, 8'h00, 1'b0,1'b0,8'h00,1'b0,1'b1}, // R1
    '{4'd11, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd1, 8'h00, 1'b0,1'b1,8'hA5,1'b0,1'b1}, // R11 write dropped
    '{4'd5,  1'b0,1'b0,1'b0,1'b1,1'b0, 2'd0, 8'h00, 1'b0,1'b0,8'h00,1'b0,1'b0}, // R5
    '{4'd8,  1'b1,1'b0,1'b0,1'b0,1'b1, 2'd1, 8'h00, 1'b0,1'b0,8'h00,1'b0,1'b0}, // R8 refresh beats row strobe
    '{4'd8,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2, 8'h00, 1'b0,1'b0,8'h00,1'b0,1'b1}, // R8
    '{4'd8,  1'b0,1'b1,1'b0,1'b0,1'b0, 2'd3, 8'h00, 1'b0,1'b1,8'h3C,1'b0,1'b1}, // R8 data intact
    '{4'd4,  1'b0,1'b0,1'b1,1'b0,1'b0, 2'd0, 8'h77, 1'b0,1'b1,8'h77,1'b0,1'b1}, // R4 overwrite
    '{4'd5,  1'b0,1'b0,1'b0,1'b1,1'b0, 2'd0, 8'h00, 1'b0,1'b0,8'h00,1'b0,1'b0}, // R5
    '{4'd1,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2, 8'h00, 1'b0,1'b0,8'h00,1'b0,1'b1}, // R1
    '{4'd5,  1'b0,1'b1,1'b0,1'b0,1'b0, 2'd3, 8'h00, 1'b0,1'b1,8'h77,1'b0,1'b1}, // R5
    '{4'd5,  1'b0,1'b0,1'b0,1'b1,1'b0, 2'd0, 8'h00, 1'b0,1'b0,8'h00,1'b0,1'b0}  // R5
  };

  task automatic idle_inputs();
    addr = '0; row_stb = 0; col_stb = 0; wr_en = 0; close_row = 0;
    refresh_go = 0; wr_data = '0;
  endtask

  task automatic cmd(input logic rs, cs, we, cl, rf, input logic [1:0] a, input logic [7:0] wd);
    row_stb = rs; col_stb = cs; wr_en = we; close_row = cl; refresh_go = rf;
    addr = a; wr_data = wd;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9: outputs cleared while reset is held
    check("R9 reset outputs", {28'd0, rd_valid, row_open, proto_err, refresh_req}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 after release", {28'd0, rd_valid, row_open, proto_err, refresh_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      row_stb = v.rs; col_stb = v.cs; wr_en = v.we; close_row = v.cl;
      refresh_go = v.rf; addr = v.a; wr_data = v.wd;
      @(negedge clk);
      idle_inputs();
      checks++;
      if (rd_valid !== v.ev || proto_err !== v.ee || row_open !== v.eo ||
          (!v.dc && rd_data !== v.ed)) begin
        fails++;
        $display("FAIL R%0d vec %0d actual v=%b d=%h e=%b o=%b expected v=%b d=%h e=%b o=%b",
                 v.req, i, rd_valid, rd_data, proto_err, row_open, v.ev, v.ed, v.ee, v.eo);
      end
    end

    // R7: request timing relative to an accepted refresh
    cmd(0,0,0,0,1, 2'd0, 8'h00);
    check("R8 req cleared", {31'd0, refresh_req}, 32'd0);
    repeat (LIM - 1) @(negedge clk);
    check("R7 not yet due", {31'd0, refresh_req}, 32'd0);
    @(negedge clk);
    check("R7 due", {31'd0, refresh_req}, 32'd1);
    repeat (3) @(negedge clk);
    check("R7 held", {31'd0, refresh_req}, 32'd1);
    cmd(0,0,0,0,1, 2'd0, 8'h00);
    check("R8 accept clears", {31'd0, refresh_req}, 32'd0);

    // R8: a full round of refreshes leaves data intact
    for (int k = 0; k < 4; k++) cmd(0,0,0,0,1, 2'd0, 8'h00);
    cmd(1,0,0,0,0, 2'd2, 8'h00);
    cmd(0,1,0,0,0, 2'd1, 8'h00);
    check("R8 col1 kept", {24'd0, rd_data}, 32'hA5);
    cmd(0,1,0,0,0, 2'd3, 8'h00);
    check("R8 col3 kept", {24'd0, rd_data}, 32'h77);

    // R6: a second fault pulse, single cycle
    cmd(1,0,0,0,0, 2'd1, 8'h00);
    check("R6 pulse", {31'd0, proto_err}, 32'd1);
    @(negedge clk);
    check("R6 pulse one cycle", {31'd0, proto_err}, 32'd0);

    // R9: reset with a row open
    rst_n = 1'b0;
    #1;
    check("R9 async clear", {29'd0, rd_valid, row_open, refresh_req}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 stays closed", {30'd0, rd_valid, row_open}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule